// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits beside the control unit of a small 8-bit processor core. It keeps a pending flag for each interrupt request line and decides when one of them is taken. The decision is made only at an instruction boundary or while the core is asleep, and only when the global interrupt enable is set. Once a request is taken, the block runs a fixed entry sequence. The sequence pushes the two program counter bytes through stack strobes, clears the global enable and loads the vector address. The block also runs the return sequence, which pops the bytes back and sets the enable again.

The block carries no data path of its own. It issues strobes, a byte select, stack pointer step pulses, a vector load with its address, and requests to set or clear the enable bit. While a sequence is in progress, `busy_o` holds the core's instruction fetch. Entry takes four cycles. It takes eight cycles when the interrupt wakes the core from sleep. A return takes four cycles.

Top module: `irq_seq`

## Requirements
- R1: After reset `busy_o` is low, every strobe output is low and `pend_o` is all zero.
- R2: A pending request is taken only while the block is idle, `gie_i` is high, and either `boundary_i` or `sleep_i` is high. A request that stays pending while an instruction is still running (boundary low, not asleep) does not start a sequence.
- R3: At a boundary where `ei_i` is high, meaning the retiring instruction set the enable, no request is taken. The next boundary may take one.
- R4: Among the pending requests, the lowest index wins. `vec_addr_o` equals `VEC_BASE + 2*index` (4 + 2*index by default).
- R5: Entry from a boundary runs for exactly four cycles after acceptance. Cycle 1 asserts `stk_wr_o` and `sp_dec_o` with `stk_hi_o`=0 (low byte). Cycle 2 asserts the same two strobes with `stk_hi_o`=1 (high byte). Cycle 3 asserts nothing. Cycle 4 asserts `vec_ld_o`.
- R6: `gie_clr_o` is asserted once during entry, in entry cycle 2.
- R7: The taken request's pending flag is cleared when the vector is loaded. Other pending flags are kept.
- R8: A request taken while asleep adds four wake cycles with no strobes before the entry sequence. The push starts in cycle 5 and `vec_ld_o` is asserted in cycle 8.
- R9: `reti_i` at an idle boundary starts a four-cycle return. Cycle 1 asserts `stk_rd_o` and `sp_inc_o` with `stk_hi_o`=1. Cycle 2 asserts the same two strobes with `stk_hi_o`=0. Cycle 4 asserts `gie_set_o`.
- R10: `busy_o` is high for every cycle of a sequence and low otherwise. A return requested at a boundary takes precedence over a pending interrupt at that boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | NUM_IRQ | Request pulses; each sets its pending flag |
| gie_i | input | 1 | Current global interrupt enable |
| ei_i | input | 1 | Retiring instruction set the enable |
| boundary_i | input | 1 | Instruction boundary this cycle |
| sleep_i | input | 1 | Core is asleep |
| reti_i | input | 1 | Retiring instruction is a return from interrupt |
| busy_o | output | 1 | Sequence in progress; stalls fetch |
| stk_wr_o | output | 1 | Stack write strobe |
| stk_rd_o | output | 1 | Stack read strobe |
| stk_hi_o | output | 1 | Byte select: 1 high PC byte, 0 low PC byte |
| sp_dec_o | output | 1 | Decrement stack pointer |
| sp_inc_o | output | 1 | Increment stack pointer |
| vec_ld_o | output | 1 | Load vector address into PC |
| vec_addr_o | output | PC_W | Vector address |
| gie_clr_o | output | 1 | Clear global enable |
| gie_set_o | output | 1 | Set global enable |
| pend_o | output | NUM_IRQ | Pending flags |

## Verification
The bench targets the exact cycle of each strobe. A design that is off by one cycle would load the vector in the wrong cycle, or push the bytes in the wrong order. The bench holds a request pending across a multi-cycle instruction and at a boundary where the enable was just set. A design that ignored the boundary rule or the enable delay would start an entry early. The bench also checks that lowest-index priority and selective clearing of the pending flag leave the losing request pending. A design with a bad priority encoder, or one that cleared all flags, would vector to the wrong address or lose a request. It also checks the eight-cycle wake-up entry, and that a return beats a pending interrupt at the same boundary.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAKE  = 2'd1,
    ST_ENTRY = 2'd2,
    ST_RET   = 2'd3
  } seq_st_e;
endpackage

// File: rtl/irq_seq_pend.sv
module irq_seq_pend #(
  parameter int NUM_IRQ = 4,
  parameter int IDX_W   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] req_i,
  input  logic               clr_i,
  input  logic [IDX_W-1:0]   clr_idx_i,
  output logic [NUM_IRQ-1:0] pend_o,
  output logic               any_o,
  output logic [IDX_W-1:0]   win_o
);
  logic [NUM_IRQ-1:0] pend_q;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      pend_q[g] <= 1'b0;
      else if (req_i[g])                                pend_q[g] <= 1'b1; // new request beats clear
      else if (clr_i && (clr_idx_i == IDX_W'(g)))       pend_q[g] <= 1'b0;
    end
  end

  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    win_o = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (pend_q[i]) win_o = IDX_W'(i);
    end
  end

  assign any_o  = |pend_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
#(
  parameter int ENTRY_CYC = 4,
  parameter int WAKE_CYC  = 4,
  parameter int RET_CYC   = 4,
  parameter int CNT_W     = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_entry_i,
  input  logic             start_wake_i,
  input  logic             start_ret_i,
  output seq_st_e          st_o,
  output logic [CNT_W-1:0] cnt_o
);
  seq_st_e          st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  always_comb begin
    unique case (st_q)
      ST_WAKE:  last = (cnt_q == CNT_W'(WAKE_CYC - 1));
      ST_ENTRY: last = (cnt_q == CNT_W'(ENTRY_CYC - 1));
      ST_RET:   last = (cnt_q == CNT_W'(RET_CYC - 1));
      default:  last = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else if (st_q == ST_IDLE) begin
      cnt_q <= '0;
      if (start_ret_i)        st_q <= ST_RET;
      else if (start_wake_i)  st_q <= ST_WAKE;
      else if (start_entry_i) st_q <= ST_ENTRY;
    end else if (last) begin
      cnt_q <= '0;
      st_q  <= (st_q == ST_WAKE) ? ST_ENTRY : ST_IDLE;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign st_o  = st_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_seq_pkg::*;
#(
  parameter int          NUM_IRQ   = 4,
  parameter int          PC_W      = 16,
  parameter logic [15:0] VEC_BASE  = 16'h0004,
  parameter int          ENTRY_CYC = 4,
  parameter int          WAKE_CYC  = 4,
  parameter int          RET_CYC   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_req_i,
  input  logic               gie_i,
  input  logic               ei_i,
  input  logic               boundary_i,
  input  logic               sleep_i,
  input  logic               reti_i,
  output logic               busy_o,
  output logic               stk_wr_o,
  output logic               stk_rd_o,
  output logic               stk_hi_o,
  output logic               sp_dec_o,
  output logic               sp_inc_o,
  output logic               vec_ld_o,
  output logic [PC_W-1:0]    vec_addr_o,
  output logic               gie_clr_o,
  output logic               gie_set_o,
  output logic [NUM_IRQ-1:0] pend_o
);
  localparam int IDX_W   = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam int MAX_CYC = (ENTRY_CYC > WAKE_CYC) ?
                           ((ENTRY_CYC > RET_CYC) ? ENTRY_CYC : RET_CYC) :
                           ((WAKE_CYC > RET_CYC) ? WAKE_CYC : RET_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  seq_st_e          st;
  logic [CNT_W-1:0] cnt;
  logic             any_pend, idle, ret_go, take;
  logic [IDX_W-1:0] win, sel_q;

  assign idle   = (st == ST_IDLE);
  assign ret_go = idle && boundary_i && reti_i;
  assign take   = idle && !ret_go && any_pend && gie_i &&
                  (sleep_i || (boundary_i && !ei_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sel_q <= '0;
    else if (take) sel_q <= win;
  end

  irq_seq_pend #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (irq_req_i),
    .clr_i     (vec_ld_o),
    .clr_idx_i (sel_q),
    .pend_o    (pend_o),
    .any_o     (any_pend),
    .win_o     (win)
  );

  irq_seq_fsm #(
    .ENTRY_CYC(ENTRY_CYC), .WAKE_CYC(WAKE_CYC), .RET_CYC(RET_CYC), .CNT_W(CNT_W)
  ) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_entry_i (take && !sleep_i),
    .start_wake_i  (take && sleep_i),
    .start_ret_i   (ret_go),
    .st_o          (st),
    .cnt_o         (cnt)
  );

  always_comb begin
    stk_wr_o  = 1'b0;
    stk_rd_o  = 1'b0;
    stk_hi_o  = 1'b0;
    sp_dec_o  = 1'b0;
    sp_inc_o  = 1'b0;
    vec_ld_o  = 1'b0;
    gie_clr_o = 1'b0;
    gie_set_o = 1'b0;
    if (st == ST_ENTRY) begin
      if (cnt == CNT_W'(0)) begin
        stk_wr_o = 1'b1;
        sp_dec_o = 1'b1;
      end
      if (cnt == CNT_W'(1)) begin
        stk_wr_o  = 1'b1;
        sp_dec_o  = 1'b1;
        stk_hi_o  = 1'b1;
        gie_clr_o = 1'b1;
      end
      if (cnt == CNT_W'(ENTRY_CYC - 1)) vec_ld_o = 1'b1;
    end else if (st == ST_RET) begin
      if (cnt == CNT_W'(0)) begin
        stk_rd_o = 1'b1;
        sp_inc_o = 1'b1;
        stk_hi_o = 1'b1;
      end
      if (cnt == CNT_W'(1)) begin
        stk_rd_o = 1'b1;
        sp_inc_o = 1'b1;
      end
      if (cnt == CNT_W'(RET_CYC - 1)) gie_set_o = 1'b1;
    end
  end

  assign busy_o     = !idle;
  assign vec_addr_o = PC_W'(VEC_BASE) + (PC_W'(sel_q) << 1);
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
  parameter int NUM_IRQ = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic boundary_i,
  input logic sleep_i,
  input logic busy_o,
  input logic stk_wr_o,
  input logic stk_rd_o,
  input logic stk_hi_o,
  input logic sp_dec_o,
  input logic sp_inc_o,
  input logic vec_ld_o,
  input logic gie_clr_o,
  input logic gie_set_o
);
  AST_NO_MIDINSTR_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !boundary_i && !sleep_i) |=> !busy_o); // R2

  AST_PUSH_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stk_wr_o && !stk_hi_o) |=> (stk_wr_o && stk_hi_o)); // R5

  AST_SP_DEC_PAIRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_dec_o |-> (stk_wr_o && !stk_rd_o)); // R5

  AST_GIE_CLR_WITH_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gie_clr_o |-> (stk_wr_o && stk_hi_o)); // R6

  AST_VEC_ENDS_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_ld_o |=> !busy_o); // R5

  AST_POP_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stk_rd_o && stk_hi_o) |=> (stk_rd_o && !stk_hi_o)); // R9

  AST_SP_INC_PAIRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_inc_o |-> (stk_rd_o && !stk_wr_o)); // R9

  AST_STROBES_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stk_wr_o || stk_rd_o || vec_ld_o || gie_clr_o || gie_set_o) |-> busy_o); // R10
endmodule

bind irq_seq irq_seq_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .boundary_i (boundary_i),
  .sleep_i    (sleep_i),
  .busy_o     (busy_o),
  .stk_wr_o   (stk_wr_o),
  .stk_rd_o   (stk_rd_o),
  .stk_hi_o   (stk_hi_o),
  .sp_dec_o   (sp_dec_o),
  .sp_inc_o   (sp_inc_o),
  .vec_ld_o   (vec_ld_o),
  .gie_clr_o  (gie_clr_o),
  .gie_set_o  (gie_set_o)
);

// File: tb/irq_seq_tb_top.sv
module irq_seq_tb_top;
  localparam int N = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] irq_req_i = '0;
  logic         gie_i = 1'b0, ei_i = 1'b0, boundary_i = 1'b0, sleep_i = 1'b0, reti_i = 1'b0;
  logic         busy_o, stk_wr_o, stk_rd_o, stk_hi_o, sp_dec_o, sp_inc_o;
  logic         vec_ld_o, gie_clr_o, gie_set_o;
  logic [15:0]  vec_addr_o;
  logic [N-1:0] pend_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  irq_seq dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_req_i(irq_req_i), .gie_i(gie_i), .ei_i(ei_i),
    .boundary_i(boundary_i), .sleep_i(sleep_i), .reti_i(reti_i), .busy_o(busy_o),
    .stk_wr_o(stk_wr_o), .stk_rd_o(stk_rd_o), .stk_hi_o(stk_hi_o), .sp_dec_o(sp_dec_o),
    .sp_inc_o(sp_inc_o), .vec_ld_o(vec_ld_o), .vec_addr_o(vec_addr_o),
    .gie_clr_o(gie_clr_o), .gie_set_o(gie_set_o), .pend_o(pend_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk_i);
  endtask

  // strobe vector {busy,wr,rd,hi,dec,inc,vld,gclr,gset}
  function automatic logic [31:0] sv();
    return {23'd0, busy_o, stk_wr_o, stk_rd_o, stk_hi_o, sp_dec_o, sp_inc_o,
            vec_ld_o, gie_clr_o, gie_set_o};
  endfunction

  task automatic raise(logic [N-1:0] m);
    irq_req_i = m; cyc(); irq_req_i = '0;
  endtask

  task automatic pulse_boundary();
    boundary_i = 1'b1; cyc(); boundary_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 strobes", sv(), 32'h0);
    chk("R1 pend", 32'(pend_o), 32'h0);
  endtask

  task automatic t_entry();
    gie_i = 1'b1;
    raise(4'b0100);
    chk("R7 pend set", 32'(pend_o), 32'h4);
    pulse_boundary();
    chk("R5 cyc1 push lo", sv(), 32'b1_1_0_0_1_0_0_0_0);
    cyc();
    chk("R5 R6 cyc2 push hi clr", sv(), 32'b1_1_0_1_1_0_0_1_0);
    cyc();
    chk("R5 cyc3 idle strobes", sv(), 32'b1_0_0_0_0_0_0_0_0);
    cyc();
    chk("R5 cyc4 vec", sv(), 32'b1_0_0_0_0_0_1_0_0);
    chk("R4 vec addr idx2", 32'(vec_addr_o), 32'h8);
    cyc();
    chk("R10 busy done", 32'(busy_o), 32'h0);
    chk("R7 pend cleared", 32'(pend_o), 32'h0);
  endtask

  task automatic t_priority();
    raise(4'b1010);
    pulse_boundary();
    cyc(3);
    chk("R4 lowest wins addr", 32'(vec_addr_o), 32'h6);
    cyc();
    chk("R7 loser kept", 32'(pend_o), 32'h8);
    pulse_boundary();
    cyc(3);
    chk("R4 second addr idx3", 32'(vec_addr_o), 32'hA);
    cyc();
    chk("R7 all clear", 32'(pend_o), 32'h0);
  endtask

  task automatic t_midinstr();
    raise(4'b0001);
    for (int i = 0; i < 5; i++) begin
      cyc();
      chk("R2 no take mid-instr", 32'(busy_o), 32'h0);
    end
    pulse_boundary();
    chk("R2 take at boundary", 32'(busy_o), 32'h1);
    cyc(3);
    chk("R4 idx0 addr", 32'(vec_addr_o), 32'h4);
    cyc();
  endtask

  task automatic t_masked();
    gie_i = 1'b0;
    raise(4'b0001);
    pulse_boundary();
    chk("R2 masked no take", 32'(busy_o), 32'h0);
    chk("R2 masked still pend", 32'(pend_o), 32'h1);
    gie_i = 1'b1;
    pulse_boundary();
    cyc(4);
  endtask

  task automatic t_ei_delay();
    raise(4'b0010);
    boundary_i = 1'b1; ei_i = 1'b1; cyc(); boundary_i = 1'b0; ei_i = 1'b0;
    chk("R3 ei boundary no take", 32'(busy_o), 32'h0);
    cyc();
    chk("R3 still idle", 32'(busy_o), 32'h0);
    pulse_boundary();
    chk("R3 next boundary takes", 32'(busy_o), 32'h1);
    cyc(4);
  endtask

  task automatic t_sleep();
    raise(4'b0100);
    sleep_i = 1'b1; cyc(); sleep_i = 1'b0;
    for (int i = 1; i <= 4; i++) begin
      chk("R8 wake no strobes", sv(), 32'b1_0_0_0_0_0_0_0_0);
      cyc();
    end
    chk("R8 cyc5 push lo", sv(), 32'b1_1_0_0_1_0_0_0_0);
    cyc(3);
    chk("R8 cyc8 vec", 32'(vec_ld_o), 32'h1);
    cyc();
    chk("R8 done", 32'(busy_o), 32'h0);
  endtask

  task automatic t_return();
    raise(4'b0001);
    gie_i = 1'b0;
    cyc();
    gie_i = 1'b1;
    boundary_i = 1'b1; reti_i = 1'b1; cyc(); boundary_i = 1'b0; reti_i = 1'b0;
    chk("R9 R10 cyc1 pop hi", sv(), 32'b1_0_1_1_0_1_0_0_0);
    cyc();
    chk("R9 cyc2 pop lo", sv(), 32'b1_0_1_0_0_1_0_0_0);
    cyc();
    chk("R9 cyc3", sv(), 32'b1_0_0_0_0_0_0_0_0);
    cyc();
    chk("R9 cyc4 gie set", sv(), 32'b1_0_0_0_0_0_0_0_1);
    cyc();
    chk("R9 done", 32'(busy_o), 32'h0);
    chk("R10 irq still pending", 32'(pend_o), 32'h1);
    pulse_boundary();
    cyc(4);
  endtask

  initial begin
    cyc(2);
    t_reset();
    rst_ni = 1'b1;
    cyc();
    t_reset();
    t_entry();
    t_priority();
    t_midinstr();
    t_masked();
    t_ei_delay();
    t_sleep();
    t_return();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule